// File: doc/BRIEF.md
# Stack-Top Cache with Block Write-Back

This block keeps the top of a process stack in a small local buffer of fast memory. Push and pop requests are served from the buffer only, and main memory sees no traffic while they run. Each buffered word belongs to a stack word address. The word with address `a` sits in slot `a mod DEPTH`. The oldest and newest entries are therefore marked by two pointers that wrap around the buffer. The stack grows toward higher addresses. A push stores at the current top address and then moves the top up by one. A pop reads the word just below the top.

When the surrounding process-switch logic requests a flush, a sequencer writes the cached region back to main memory as bursts of `BURST` words. Each burst starts on a `BURST`-aligned word address. The bursts go out from the oldest block to the newest. A per-word mask marks which words of each burst belong to the cached region. After the last burst is accepted, every valid flag is cleared and both pointers meet at the unchanged top address, so the buffer is empty. Later pushes continue directly above the flushed words.

Pushing into a full buffer and popping from an empty one are reported on one-cycle flags. The process-switch logic uses these flags to decide when to change tasks. Refilling the buffer from memory after an underflow is not part of this block.

Top module: `stack_top_cache`

## Requirements
- R1: A push that is accepted stores the word in the buffer only. `memValid` stays low at all times outside a flush.
- R2: A pop on a non-empty buffer returns the most recently pushed word that has not yet been popped (LIFO). The word appears on `popData` with `popValid` high in the cycle after the request.
- R3: A push while the buffer holds `DEPTH` words and no pop is requested is dropped and raises `overflow` for one cycle. The buffer contents are left unchanged.
- R4: A pop on an empty buffer raises `underflow` and `popValid` for one cycle and returns zero on `popData`.
- R5: When push and pop are requested together, the pop is performed first and the push second. The pop returns the old top (or zero with `underflow` if the buffer is empty), the new word becomes the top, and no overflow can occur.
- R6: The word at stack address `a` lives in slot `a mod DEPTH`. The pointers keep counting across flushes and wrap around the buffer, so a full buffer may start at any slot.
- R7: A flush issues one burst for each `BURST`-aligned block that overlaps the cached region. Bursts go out in ascending address order, and `memAddr` is the word address of the block's first word.
- R8: Bit `i` of `memMask` is set exactly when word `memAddr+i` lies in the cached region. Word `i` of `memData` sits at bits `[i*WIDTH +: WIDTH]` and is zero when its mask bit is clear.
- R9: A burst is transferred on a cycle where both `memValid` and `memReady` are high. While `memReady` is low, address, data and mask hold steady.
- R10: `flushDone` is high for exactly one cycle, in the cycle after the last burst is accepted. From then on the buffer is empty, all valid flags are clear, and the top address is unchanged.
- R11: `busy` is high in the cycle `flushReq` is asserted and for the whole flush, including the `flushDone` cycle. Push and pop requests during those cycles are ignored.
- R12: A flush of an empty buffer issues no burst and raises `flushDone` in the cycle after the request.
- R13: `full` is high exactly when `DEPTH` words are held, and `empty` is high exactly when none are held. After reset the buffer is empty, the top address is `RESET_TOP`, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| pushEn | input | 1 | Push request |
| pushData | input | WIDTH | Word to push |
| popEn | input | 1 | Pop request |
| flushReq | input | 1 | Start a write-back and invalidate |
| popData | output | WIDTH | Popped word, zero on underflow or when no pop |
| popValid | output | 1 | Pulse one cycle after a pop request |
| overflow | output | 1 | Pulse: a push was dropped |
| underflow | output | 1 | Pulse: a pop found the buffer empty |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| busy | output | 1 | Push and pop are refused |
| memValid | output | 1 | Burst on the memory port is valid |
| memReady | input | 1 | Memory accepts the burst |
| memAddr | output | AW | Aligned word address of the burst |
| memData | output | BURST*WIDTH | Burst words, word i in bits [i*WIDTH +: WIDTH] |
| memMask | output | BURST | Per-word write enable |
| flushDone | output | 1 | Pulse: write-back finished |

## Verification
A wrong fill count or top address shows up at the ports in the next cycle. It flips `full` or `empty`, raises a false `overflow` or `underflow`, or makes a pop return the wrong word. A pointer that wrapped incorrectly may only show at the next flush, as a burst with the wrong aligned address, a mask bit set outside the cached region, or a word taken from the wrong slot. For that reason the stimulus runs flushes from several unaligned starting addresses, one of them on a full buffer that wraps. Valid flags that are not cleared show immediately through the checker's comparison with the fill count.

// File: rtl/stc_pkg.sv
package stc_pkg;

  // strobes from the control to the datapath, one cycle each
  typedef struct packed {
    logic push;        // perform a push request this cycle
    logic pop;         // perform a pop request this cycle
    logic startFlush;  // load the first block address
    logic nextBlk;     // advance to the next block
    logic clearAll;    // invalidate every slot and empty the buffer
  } stcStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_DONE
  } stcState_t;

endpackage

// File: rtl/stc_datapath.sv
module stc_datapath
  import stc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  parameter int AW    = 16,
  parameter logic [AW-1:0] RESET_TOP = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  stcStrobe_t             strobe,
  input  logic [WIDTH-1:0]       pushData,
  output logic [WIDTH-1:0]       popData,
  output logic                   popValid,
  output logic                   overflow,
  output logic                   underflow,
  output logic                   full,
  output logic                   empty,
  output logic                   lastBlock,
  output logic [AW-1:0]          memAddr,
  output logic [BURST*WIDTH-1:0] memData,
  output logic [BURST-1:0]       memMask,
  output logic [DEPTH-1:0]       validFlags,
  output logic [$clog2(DEPTH+1)-1:0] fillCount
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] BLK_MASK = ~AW'(BURST - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [DEPTH-1:0] validBits;
  logic [AW-1:0]    topAddr;
  logic [AW-1:0]    tailAddr;
  logic [AW-1:0]    blkAddr;
  logic [AW-1:0]    lastBlk;
  logic [AW-1:0]    popAddr;
  logic [AW-1:0]    pushAddr;
  logic [PW-1:0]    popSlot;
  logic [PW-1:0]    pushSlot;
  logic [CW-1:0]    count;
  logic             popHit;
  logic             pushOk;

  // pointer arithmetic: the pop is resolved before the push
  always_comb begin
    tailAddr = topAddr - AW'(count);
    popHit   = strobe.pop && (count != '0);
    popAddr  = topAddr - AW'(1);
    popSlot  = popAddr[PW-1:0];
    pushOk   = strobe.push && ((count - CW'(popHit)) != FULL_CNT);
    pushAddr = topAddr - AW'(popHit);
    pushSlot = pushAddr[PW-1:0];
    lastBlk  = popAddr & BLK_MASK;
  end

  // storage array, no reset needed
  always_ff @(posedge clk) begin
    if (pushOk) store[pushSlot] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      count     <= '0;
      topAddr   <= RESET_TOP;
      blkAddr   <= '0;
      popData   <= '0;
      popValid  <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      popValid  <= strobe.pop;
      underflow <= strobe.pop && (count == '0);
      overflow  <= strobe.push && !pushOk;
      popData   <= (popHit && validBits[popSlot]) ? store[popSlot] : '0;
      if (strobe.clearAll) begin
        validBits <= '0;
        count     <= '0;
      end else begin
        if (popHit) validBits[popSlot]  <= 1'b0;
        if (pushOk) validBits[pushSlot] <= 1'b1;
        count <= count - CW'(popHit) + CW'(pushOk);
      end
      topAddr <= topAddr - AW'(popHit) + AW'(pushOk);
      if (strobe.startFlush)   blkAddr <= tailAddr & BLK_MASK;
      else if (strobe.nextBlk) blkAddr <= blkAddr + AW'(BURST);
    end
  end

  // burst assembly: one lane per word of the block
  for (genvar i = 0; i < BURST; i++) begin : gLane
    logic [AW-1:0] wordAddr;
    logic [PW-1:0] wordSlot;
    logic          inWindow;
    always_comb begin
      wordAddr = blkAddr + AW'(i);
      wordSlot = wordAddr[PW-1:0];
      inWindow = (wordAddr - tailAddr) < AW'(count);
    end
    assign memMask[i] = inWindow && validBits[wordSlot];
    assign memData[i*WIDTH +: WIDTH] = memMask[i] ? store[wordSlot] : '0;
  end

  assign full       = (count == FULL_CNT);
  assign empty      = (count == '0);
  assign lastBlock  = (blkAddr == lastBlk);
  assign memAddr    = blkAddr;
  assign validFlags = validBits;
  assign fillCount  = count;

endmodule

// File: rtl/stc_control.sv
module stc_control
  import stc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushEn,
  input  logic       popEn,
  input  logic       flushReq,
  input  logic       memReady,
  input  logic       bufEmpty,
  input  logic       lastBlock,
  output stcStrobe_t strobe,
  output logic       busy,
  output logic       memValid,
  output logic       flushDone
);

  stcState_t state;
  stcState_t nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (flushReq) begin
          strobe.startFlush = 1'b1;
          if (bufEmpty) begin
            strobe.clearAll = 1'b1;
            nextState       = ST_DONE;
          end else begin
            nextState = ST_FLUSH;
          end
        end else begin
          strobe.push = pushEn;
          strobe.pop  = popEn;
        end
      end
      ST_FLUSH: begin
        if (memReady) begin
          if (lastBlock) begin
            strobe.clearAll = 1'b1;
            nextState       = ST_DONE;
          end else begin
            strobe.nextBlk = 1'b1;
          end
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy      = (state != ST_IDLE) || flushReq;
  assign memValid  = (state == ST_FLUSH);
  assign flushDone = (state == ST_DONE);

endmodule

// File: rtl/stack_top_cache.sv
module stack_top_cache
  import stc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  parameter int AW    = 16,
  parameter logic [AW-1:0] RESET_TOP = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pushEn,
  input  logic [WIDTH-1:0]       pushData,
  input  logic                   popEn,
  input  logic                   flushReq,
  output logic [WIDTH-1:0]       popData,
  output logic                   popValid,
  output logic                   overflow,
  output logic                   underflow,
  output logic                   full,
  output logic                   empty,
  output logic                   busy,
  output logic                   memValid,
  input  logic                   memReady,
  output logic [AW-1:0]          memAddr,
  output logic [BURST*WIDTH-1:0] memData,
  output logic [BURST-1:0]       memMask,
  output logic                   flushDone
);

  localparam int CW = $clog2(DEPTH + 1);

  stcStrobe_t       strobe;
  logic             lastBlock;
  logic [DEPTH-1:0] validFlags;
  logic [CW-1:0]    fillCount;

  stc_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .pushEn    (pushEn),
    .popEn     (popEn),
    .flushReq  (flushReq),
    .memReady  (memReady),
    .bufEmpty  (empty),
    .lastBlock (lastBlock),
    .strobe    (strobe),
    .busy      (busy),
    .memValid  (memValid),
    .flushDone (flushDone)
  );

  stc_datapath #(
    .WIDTH     (WIDTH),
    .DEPTH     (DEPTH),
    .BURST     (BURST),
    .AW        (AW),
    .RESET_TOP (RESET_TOP)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pushData   (pushData),
    .popData    (popData),
    .popValid   (popValid),
    .overflow   (overflow),
    .underflow  (underflow),
    .full       (full),
    .empty      (empty),
    .lastBlock  (lastBlock),
    .memAddr    (memAddr),
    .memData    (memData),
    .memMask    (memMask),
    .validFlags (validFlags),
    .fillCount  (fillCount)
  );

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  parameter int AW    = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       pushEn,
  input logic                       popEn,
  input logic                       busy,
  input logic                       full,
  input logic                       empty,
  input logic                       overflow,
  input logic                       underflow,
  input logic                       popValid,
  input logic [WIDTH-1:0]           popData,
  input logic                       memValid,
  input logic                       memReady,
  input logic [AW-1:0]              memAddr,
  input logic [BURST*WIDTH-1:0]     memData,
  input logic [BURST-1:0]           memMask,
  input logic                       flushDone,
  input logic [DEPTH-1:0]           validFlags,
  input logic [$clog2(DEPTH+1)-1:0] fillCount
);

  localparam int BW = $clog2(BURST);

  assert_no_mem_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memValid);

  assert_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && pushEn && !popEn && full) |=> (overflow && full));

  assert_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && popEn && empty) |=> (underflow && popValid && popData == '0));

  assert_pair_no_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && pushEn && popEn && !empty) |=> (popValid && !overflow && !underflow));

  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddr[BW-1:0] == '0));

  assert_mask_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memMask != '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=>
      (memValid && $stable(memAddr) && $stable(memData) && $stable(memMask)));

  assert_done_clean_R10: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |-> (empty && validFlags == '0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushDone);

  assert_busy_flush_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memValid || flushDone) |-> busy);

  assert_flags_match_R13: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validFlags) == int'(fillCount));

  assert_full_empty_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

endmodule

bind stack_top_cache stc_checker #(
  .WIDTH (WIDTH),
  .DEPTH (DEPTH),
  .BURST (BURST),
  .AW    (AW)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .pushEn     (pushEn),
  .popEn      (popEn),
  .busy       (busy),
  .full       (full),
  .empty      (empty),
  .overflow   (overflow),
  .underflow  (underflow),
  .popValid   (popValid),
  .popData    (popData),
  .memValid   (memValid),
  .memReady   (memReady),
  .memAddr    (memAddr),
  .memData    (memData),
  .memMask    (memMask),
  .flushDone  (flushDone),
  .validFlags (validFlags),
  .fillCount  (fillCount)
);

// File: tb/stack_top_cache_test.sv
module stack_top_cache_test;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 32;
  localparam int DEPTH = 16;
  localparam int BURST = 4;
  localparam int AW    = 16;
  localparam int NV    = 11;

  // row: {op[1:0] (1 push, 2 pop, 3 both), data, expected popData,
  //       flags {popValid, overflow, underflow, full, empty}}
  localparam logic [70:0] VEC [NV] = '{
    {2'd2, 32'h0,         32'h0,         5'b10101},
    {2'd1, 32'h1111_0001, 32'h0,         5'b00000},
    {2'd1, 32'h1111_0002, 32'h0,         5'b00000},
    {2'd1, 32'h1111_0003, 32'h0,         5'b00000},
    {2'd2, 32'h0,         32'h1111_0003, 5'b10000},
    {2'd3, 32'h2222_0001, 32'h1111_0002, 5'b10000},
    {2'd2, 32'h0,         32'h2222_0001, 5'b10000},
    {2'd2, 32'h0,         32'h1111_0001, 5'b10001},
    {2'd2, 32'h0,         32'h0,         5'b10101},
    {2'd3, 32'h3333_0001, 32'h0,         5'b10100},
    {2'd2, 32'h0,         32'h3333_0001, 5'b10001}
  };

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   pushEn = 1'b0;
  logic [WIDTH-1:0]       pushData = '0;
  logic                   popEn = 1'b0;
  logic                   flushReq = 1'b0;
  logic                   memReady = 1'b0;
  logic [WIDTH-1:0]       popData;
  logic                   popValid, overflow, underflow, full, empty, busy;
  logic                   memValid, flushDone;
  logic [AW-1:0]          memAddr;
  logic [BURST*WIDTH-1:0] memData;
  logic [BURST-1:0]       memMask;

  int checks = 0;
  int fails  = 0;

  logic [AW-1:0]          eAddr [4];
  logic [BURST-1:0]       eMask [4];
  logic [BURST*WIDTH-1:0] eData [4];

  stack_top_cache #(.WIDTH(WIDTH), .DEPTH(DEPTH), .BURST(BURST), .AW(AW)) uut (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushData(pushData), .popEn(popEn),
    .flushReq(flushReq), .popData(popData), .popValid(popValid),
    .overflow(overflow), .underflow(underflow), .full(full), .empty(empty),
    .busy(busy), .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .memMask(memMask), .flushDone(flushDone)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the clock
  task automatic doOp(input logic [1:0] op, input logic [WIDTH-1:0] d);
    pushEn   = op[0];
    popEn    = op[1];
    pushData = d;
    @(posedge clk);
    @(negedge clk);
    pushEn = 1'b0;
    popEn  = 1'b0;
  endtask

  task automatic pushRun(input int n, input logic [WIDTH-1:0] base);
    for (int i = 0; i < n; i++) begin
      doOp(2'd1, base + WIDTH'(i));
      check(!memValid && !overflow, "R1", "push quiet", {memValid, overflow}, 0);
    end
  endtask

  // flush with push requests held high to show they are ignored (R11)
  task automatic runFlush(input int nExp, input bit stall, input string req);
    int got = 0;
    int validCycles = 0;
    int cyc = 0;
    bit doneSeen = 1'b0;
    flushReq = 1'b1;
    pushEn   = 1'b1;
    pushData = 32'hDEAD_BEEF;
    #1;
    check(busy, "R11", "busy on request", busy, 1);
    @(posedge clk);
    @(negedge clk);
    flushReq = 1'b0;
    while (!doneSeen && cyc < 100) begin
      memReady = stall ? (cyc % 2 == 1) : 1'b1;
      check(busy, "R11", "busy in flush", busy, 1);
      if (flushDone) begin
        doneSeen = 1'b1;
      end else begin
        if (memValid) begin
          validCycles++;
          if (memReady) begin
            if (got < nExp) begin
              check(memAddr == eAddr[got], req, "burst addr", memAddr, eAddr[got]);
              check(memMask == eMask[got], "R8", "burst mask", memMask, eMask[got]);
              check(memData == eData[got], "R8", "burst data", memData, eData[got]);
            end
            got++;
          end
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
      end
    end
    memReady = 1'b0;
    pushEn   = 1'b0;
    check(doneSeen, "R10", "done seen", doneSeen, 1);
    check(got == nExp, req, "burst count", got, nExp);
    check(empty && !full, "R10", "empty at done", {full, empty}, 2'b01);
    if (stall) check(validCycles == 2 * nExp, "R9", "stall cycles", validCycles, 2 * nExp);
    @(posedge clk);
    @(negedge clk);
    check(!flushDone && !busy, "R10", "done one cycle", {flushDone, busy}, 0);
  endtask

  initial begin
    // reset
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(empty && !full && !busy && !memValid && !popValid && !overflow &&
          !underflow && !flushDone, "R13", "reset state",
          {empty, full, busy, memValid, popValid, overflow, underflow, flushDone},
          8'b1000_0000);

    // vector table: LIFO, paired requests, underflow
    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      logic [31:0] d, expD;
      logic [4:0] fl;
      string tag;
      {op, d, expD, fl} = VEC[v];
      doOp(op, d);
      tag = (op == 2'd3) ? "R5" : fl[2] ? "R4" : (op == 2'd2) ? "R2" : "R1";
      check(popData == expD, tag, "popData", popData, expD);
      check({popValid, overflow, underflow, full, empty} == fl, tag, "flags",
            {popValid, overflow, underflow, full, empty}, fl);
      check(!memValid, "R1", "no memory traffic", memValid, 0);
    end

    // six words at addresses 0..5, flush without stalls
    pushRun(6, 32'hA000_0000);
    eAddr[0] = 16'd0; eMask[0] = 4'b1111;
    eData[0] = {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000};
    eAddr[1] = 16'd4; eMask[1] = 4'b0011;
    eData[1] = {32'h0, 32'h0, 32'hA000_0005, 32'hA000_0004};
    runFlush(2, 1'b0, "R7");
    // push attempted during the flush must not be stored
    doOp(2'd2, 32'h0);
    check(underflow && popData == 0, "R11", "push ignored while busy",
          {underflow, popData}, {1'b1, 32'h0});

    // three words at addresses 6..8, flush with memory stalls
    pushRun(3, 32'hE000_0000);
    eAddr[0] = 16'd4; eMask[0] = 4'b1100;
    eData[0] = {32'hE000_0001, 32'hE000_0000, 32'h0, 32'h0};
    eAddr[1] = 16'd8; eMask[1] = 4'b0001;
    eData[1] = {32'h0, 32'h0, 32'h0, 32'hE000_0002};
    runFlush(2, 1'b1, "R6");

    // empty flush
    runFlush(0, 1'b0, "R12");

    // fill from address 9: wraps around the buffer
    pushRun(16, 32'hF000_0000);
    check(full && !empty, "R13", "full after DEPTH pushes", {full, empty}, 2'b10);
    doOp(2'd1, 32'h5555_5555);
    check(overflow && full, "R3", "overflow on full", {overflow, full}, 2'b11);
    doOp(2'd2, 32'h0);
    check(popData == 32'hF000_000F, "R3", "dropped push left top", popData, 32'hF000_000F);
    eAddr[0] = 16'd8;  eMask[0] = 4'b1110;
    eData[0] = {32'hF000_0002, 32'hF000_0001, 32'hF000_0000, 32'h0};
    eAddr[1] = 16'd12; eMask[1] = 4'b1111;
    eData[1] = {32'hF000_0006, 32'hF000_0005, 32'hF000_0004, 32'hF000_0003};
    eAddr[2] = 16'd16; eMask[2] = 4'b1111;
    eData[2] = {32'hF000_000A, 32'hF000_0009, 32'hF000_0008, 32'hF000_0007};
    eAddr[3] = 16'd20; eMask[3] = 4'b1111;
    eData[3] = {32'hF000_000E, 32'hF000_000D, 32'hF000_000C, 32'hF000_000B};
    runFlush(4, 1'b1, "R6");

    // top address kept across the flush: next word lands at 24
    pushRun(1, 32'h7777_0000);
    eAddr[0] = 16'd24; eMask[0] = 4'b0001;
    eData[0] = {32'h0, 32'h0, 32'h0, 32'h7777_0000};
    runFlush(1, 1'b0, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule